// File: doc/BRIEF.md
# Conversion Sequence Controller for a Multiplexed ADC

This block sits between a register bus and the timing engine of a successive-approximation converter. It runs a sequence of one to eight conversions. For each conversion it tells the engine which analog channel to convert. It stores every returned result in one slot of a small result register file.

A sequence can take all its samples from one channel, or it can walk upward through the channels. A sequence can run once or repeat without stopping. Results can either restart at slot 0 for every sequence, or continue around the file as a ring.

The block keeps these flags:
- a completion flag for each slot;
- a sequence-done flag;
- a flag that reports an unread slot being overwritten.

It also drives an interrupt. An external trigger input starts another sequence when the block is idle. The analog work and the formatting of the result are done elsewhere.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Register 1 bits [3:0] hold the length code. When bit 3 is set, or when the code is 0, a sequence has 8 conversions. Codes 1 to 7 give that many conversions. Register 1 reads 0x0004 after reset.
- R2: Register 2 bits [2:0] hold the first channel and bit 8 selects walking mode. With bit 8 clear, every conversion uses the first channel. With bit 8 set, each later conversion uses the next channel code, and code 7 is followed by 0.
- R3: Register 2 bit 9 selects repeat mode. With bit 9 clear, one sequence runs. With bit 9 set, sequences repeat, each starting again at the first channel. The done flag (status bit 15) is set at the end of every sequence.
- R4: The result pointer reads in status bits [2:0].
  - When register 1 bit 4 is clear, the pointer returns to slot 0 after each sequence.
  - When bit 4 is set, the pointer keeps advancing across sequences and wraps from 7 to 0.
  - A write to register 0, 1 or 2 clears the pointer.
- R5: Storing a result in slot x sets bit x of the flag register (register 4). A write to register 2 clears all of these bits.
- R6: Register 0 bit 1 selects fast clear. With fast clear off, reading slot x (address 8+x) clears flag x only when the bus read just before it was a read of register 4. Otherwise the flag is unchanged.
- R7: With fast clear on, reading slot x clears flag x and also clears the done flag.
- R8: Writing a 1 to status bit 15 clears the done flag. A write to register 2 also clears it.
- R9: Storing a result in a slot whose flag is still set sets the overrun flag (status bit 14). Writing a 1 to status bit 14 clears it, and so does a write to register 2.
- R10: Status bit 13 and the `irq` output equal the done flag ANDed with the enable in register 0 bit 0. They are 0 whenever the enable is 0.
- R11: A write to register 2 aborts any running sequence and starts a new one. A write to register 0 or 1 aborts without starting, so no further conversion is requested.
- R12: A status write that has bits 15 and 14 clear leaves the pointer and the flags unchanged.
- R13: A `trig_req` pulse while the block is idle starts a sequence. It uses the stored channel settings and keeps the existing pointer and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects take place at the clock edge) |
| bus_addr | input | 4 | Register address. Bit 3 set selects result slot [2:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| conv_start | output | 1 | One-cycle request for a conversion |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_abort | output | 1 | Cancels the conversion in flight |
| conv_done | input | 1 | Conversion result valid |
| conv_data | input | 10 | Conversion result |
| trig_req | input | 1 | Trigger request |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and reads act at the clock edge they straddle, and read data is combinational. Each check therefore samples status, flags and the pointer in the cycle right after the bus access that caused the change.

A conversion is requested in the cycle after the start write. The bench's model of the engine returns the result three cycles after it sees the request, and the slot and its flag update at the edge that consumes that result. The bench waits for `irq` before judging a whole sequence. It compares the channels requested, and the results stored, against what it computes from the length code, the walking mode and the first channel.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
   localparam int LEN_CODE_W = 4;
   localparam int CNT_W      = 3;
   localparam int BUS_W      = 16;

   localparam logic [2:0] REG_CTRL   = 3'd0;
   localparam logic [2:0] REG_SEQCFG = 3'd1;
   localparam logic [2:0] REG_START  = 3'd2;
   localparam logic [2:0] REG_STAT   = 3'd3;
   localparam logic [2:0] REG_FLAGS  = 3'd4;

   // conversions per sequence minus one
   function automatic logic [CNT_W-1:0] len_minus_one(input logic [LEN_CODE_W-1:0] code);
      if (code[3] || (code[2:0] == 3'd0))
         return 3'd7;
      return code[2:0] - 3'd1;
   endfunction
endpackage

// File: rtl/adc_seq_engine.sv
`timescale 1ns/1ps
module adc_seq_engine
   import adc_seq_pkg::*;
#(
   parameter int CH_W  = 3,
   parameter int SLOTS = 8,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             start_i,
   input  logic             trig_i,
   input  logic             done_i,
   input  logic [CH_W-1:0]  start_chan_i,
   input  logic [CH_W-1:0]  base_chan_i,
   input  logic             multi_i,
   input  logic             scan_i,
   input  logic             fifo_i,
   input  logic [CNT_W-1:0] len_m1_i,
   output logic             conv_start_o,
   output logic [CH_W-1:0]  conv_chan_o,
   output logic             conv_abort_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_slot_o,
   output logic             seq_end_o,
   output logic [PTR_W-1:0] ptr_o
);
   logic             running, busy;
   logic [CNT_W-1:0] count;
   logic [CH_W-1:0]  chan;
   logic [PTR_W-1:0] ptr, ptr_inc;

   generate
      if ((1 << PTR_W) == SLOTS) begin : g_wrap_pow2
         assign ptr_inc = ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_inc = (ptr == PTR_W'(SLOTS - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   assign conv_start_o = running && !busy && !abort_i;
   assign conv_abort_o = abort_i && busy;
   assign wr_en_o      = done_i && busy && !abort_i;
   assign seq_end_o    = wr_en_o && (count == len_m1_i);
   assign wr_slot_o    = ptr;
   assign ptr_o        = ptr;
   assign conv_chan_o  = chan;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         busy    <= 1'b0;
         count   <= '0;
         chan    <= '0;
         ptr     <= '0;
      end else if (abort_i) begin
         running <= start_i;
         busy    <= 1'b0;
         count   <= '0;
         ptr     <= '0;
         if (start_i) chan <= start_chan_i;
      end else begin
         if (trig_i && !running) begin
            running <= 1'b1;
            count   <= '0;
            chan    <= base_chan_i;
         end
         if (conv_start_o) busy <= 1'b1;
         if (wr_en_o) begin
            busy <= 1'b0;
            ptr  <= ptr_inc;
            if (seq_end_o) begin
               count <= '0;
               if (!fifo_i) ptr <= '0;
               if (scan_i) chan <= base_chan_i;
               else running <= 1'b0;
            end else begin
               count <= count + 1'b1;
               if (multi_i) chan <= chan + 1'b1;
            end
         end
      end
   end

   p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);
   p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && !start_i) |=> !conv_start_o);
   p_abort_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (ptr_o == '0));
   p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= len_m1_i);
   p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !multi_i && !seq_end_o) |=> (conv_chan_o == $past(conv_chan_o)));
endmodule

// File: rtl/adc_seq_flags.sv
`timescale 1ns/1ps
module adc_seq_flags #(
   parameter int RES_W = 10,
   parameter int SLOTS = 8,
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [PTR_W-1:0] wr_slot_i,
   input  logic [RES_W-1:0] wr_data_i,
   input  logic             seq_end_i,
   input  logic             clear_all_i,
   input  logic             fast_clr_i,
   input  logic             flags_rd_i,
   input  logic             res_rd_i,
   input  logic             any_rd_i,
   input  logic [PTR_W-1:0] res_slot_i,
   input  logic             done_w1c_i,
   input  logic             ovr_w1c_i,
   output logic [SLOTS-1:0] ccf_o,
   output logic             seq_done_o,
   output logic             ovr_o,
   output logic [RES_W-1:0] rd_res_o
);
   logic [RES_W-1:0] res_q [SLOTS];
   logic             armed;
   logic             slot_clr_ok;

   assign slot_clr_ok = res_rd_i && (fast_clr_i || armed);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q[i] <= '0;
            ccf_o[i] <= 1'b0;
         end else begin
            if (wr_en_i && (wr_slot_i == PTR_W'(i))) res_q[i] <= wr_data_i;
            if (clear_all_i)
               ccf_o[i] <= 1'b0;
            else if (wr_en_i && (wr_slot_i == PTR_W'(i)))
               ccf_o[i] <= 1'b1;
            else if (slot_clr_ok && (res_slot_i == PTR_W'(i)))
               ccf_o[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_res_o = '0;
      for (int i = 0; i < SLOTS; i++)
         if (res_slot_i == PTR_W'(i)) rd_res_o = res_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         seq_done_o <= 1'b0;
         ovr_o      <= 1'b0;
      end else begin
         if (clear_all_i) armed <= 1'b0;
         else if (flags_rd_i) armed <= 1'b1;
         else if (any_rd_i) armed <= 1'b0;

         if (clear_all_i) seq_done_o <= 1'b0;
         else if (seq_end_i) seq_done_o <= 1'b1;
         else if (done_w1c_i || (res_rd_i && fast_clr_i)) seq_done_o <= 1'b0;

         if (clear_all_i) ovr_o <= 1'b0;
         else if (wr_en_i && ccf_o[wr_slot_i]) ovr_o <= 1'b1;
         else if (ovr_w1c_i) ovr_o <= 1'b0;
      end
   end

   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> ccf_o[$past(wr_slot_i)]);
   p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all_i |=> (ccf_o == '0) && !seq_done_o && !ovr_o);
   p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && ccf_o[wr_slot_i]) |=> ovr_o);
   p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end_i |=> seq_done_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int SLOTS = 8,
   parameter int CH_W  = 3,
   localparam int PTR_W  = $clog2(SLOTS),
   localparam int ADDR_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_chan,
   output logic              conv_abort,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data,
   input  logic              trig_req,
   output logic              irq
);
   generate
      if (SLOTS < 8) begin : g_bad_slots
         $error("SLOTS must hold a full sequence of 8");
      end
      if (RES_W < 1 || RES_W > BUS_W) begin : g_bad_res
         $error("RES_W must fit the bus");
      end
      if (CH_W < 1 || CH_W > 8) begin : g_bad_ch
         $error("CH_W out of range");
      end
   endgenerate

   logic                  irq_en, fast_clr, fifo_en, multi, scan;
   logic [LEN_CODE_W-1:0] len_code;
   logic [CH_W-1:0]       base_chan;
   logic [BUS_W-1:0]      wdata_unused;

   logic       is_res;
   logic [2:0] reg_sel;
   logic       ctl_wr, start_wr, stat_wr, flags_rd, res_rd;

   logic             wr_en, seq_end;
   logic [PTR_W-1:0] wr_slot, ptr;
   logic [SLOTS-1:0] ccf;
   logic             seq_done, ovr, irq_flag;
   logic [RES_W-1:0] rd_res;

   assign wdata_unused = bus_wdata;
   assign is_res   = bus_addr[ADDR_W-1];
   assign reg_sel  = bus_addr[2:0];
   assign ctl_wr   = bus_wr && !is_res && (reg_sel == REG_CTRL || reg_sel == REG_SEQCFG
                                           || reg_sel == REG_START);
   assign start_wr = bus_wr && !is_res && (reg_sel == REG_START);
   assign stat_wr  = bus_wr && !is_res && (reg_sel == REG_STAT);
   assign flags_rd = bus_rd && !is_res && (reg_sel == REG_FLAGS);
   assign res_rd   = bus_rd && is_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en    <= 1'b0;
         fast_clr  <= 1'b0;
         len_code  <= 4'd4;
         fifo_en   <= 1'b0;
         base_chan <= '0;
         multi     <= 1'b0;
         scan      <= 1'b0;
      end else if (bus_wr && !is_res) begin
         case (reg_sel)
            REG_CTRL: begin
               irq_en   <= bus_wdata[0];
               fast_clr <= bus_wdata[1];
            end
            REG_SEQCFG: begin
               len_code <= bus_wdata[3:0];
               fifo_en  <= bus_wdata[4];
            end
            REG_START: begin
               base_chan <= bus_wdata[CH_W-1:0];
               multi     <= bus_wdata[8];
               scan      <= bus_wdata[9];
            end
            default: ;
         endcase
      end
   end

   adc_seq_engine #(.CH_W(CH_W), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .abort_i      (ctl_wr),
      .start_i      (start_wr),
      .trig_i       (trig_req),
      .done_i       (conv_done),
      .start_chan_i (bus_wdata[CH_W-1:0]),
      .base_chan_i  (base_chan),
      .multi_i      (multi),
      .scan_i       (scan),
      .fifo_i       (fifo_en),
      .len_m1_i     (len_minus_one(len_code)),
      .conv_start_o (conv_start),
      .conv_chan_o  (conv_chan),
      .conv_abort_o (conv_abort),
      .wr_en_o      (wr_en),
      .wr_slot_o    (wr_slot),
      .seq_end_o    (seq_end),
      .ptr_o        (ptr)
   );

   adc_seq_flags #(.RES_W(RES_W), .SLOTS(SLOTS), .PTR_W(PTR_W)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en),
      .wr_slot_i   (wr_slot),
      .wr_data_i   (conv_data),
      .seq_end_i   (seq_end),
      .clear_all_i (start_wr),
      .fast_clr_i  (fast_clr),
      .flags_rd_i  (flags_rd),
      .res_rd_i    (res_rd),
      .any_rd_i    (bus_rd),
      .res_slot_i  (bus_addr[PTR_W-1:0]),
      .done_w1c_i  (stat_wr && bus_wdata[15]),
      .ovr_w1c_i   (stat_wr && bus_wdata[14]),
      .ccf_o       (ccf),
      .seq_done_o  (seq_done),
      .ovr_o       (ovr),
      .rd_res_o    (rd_res)
   );

   assign irq_flag = irq_en && seq_done;
   assign irq      = irq_flag;

   always_comb begin
      bus_rdata = '0;
      if (is_res) begin
         bus_rdata[RES_W-1:0] = rd_res;
      end else begin
         case (reg_sel)
            REG_CTRL:   bus_rdata[1:0] = {fast_clr, irq_en};
            REG_SEQCFG: bus_rdata[4:0] = {fifo_en, len_code};
            REG_START: begin
               bus_rdata[CH_W-1:0] = base_chan;
               bus_rdata[9:8]      = {scan, multi};
            end
            REG_STAT: begin
               bus_rdata[15:13]     = {seq_done, ovr, irq_flag};
               bus_rdata[PTR_W-1:0] = ptr;
            end
            REG_FLAGS:  bus_rdata[SLOTS-1:0] = ccf;
            default:    bus_rdata = '0;
         endcase
      end
   end

   p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end && irq_en) |=> irq);
   p_stat_keeps_ptr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !conv_done) |=> (ptr == $past(ptr)));
endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        conv_start, conv_abort, conv_done, trig_req, irq;
   logic [2:0]  conv_chan;
   logic [9:0]  conv_data;

   int nchk = 0, nfail = 0;
   int nconv = 0, nreq = 0;
   int log_chan [8192];
   int log_data [8192];

   always #4 clk = ~clk;

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_abort(conv_abort),
      .conv_done(conv_done), .conv_data(conv_data), .trig_req(trig_req), .irq(irq)
   );

   // model of the conversion timing engine
   initial begin
      int cd;
      int pchan, pdata;
      cd = 0; pchan = 0; pdata = 0;
      conv_done = 1'b0;
      conv_data = '0;
      forever begin
         @(negedge clk);
         #2;
         conv_done = 1'b0;
         if (rst_n) begin
            if (conv_abort) begin
               cd = 0;
            end else if (cd > 0) begin
               cd--;
               if (cd == 0) begin
                  conv_done = 1'b1;
                  conv_data = 10'(pdata);
                  if (nconv < 8192) begin
                     log_chan[nconv] = pchan;
                     log_data[nconv] = pdata;
                  end
                  nconv++;
               end
            end else if (conv_start) begin
               pchan = int'(conv_chan);
               pdata = (nreq * 29 + pchan * 7 + 3) % 1024;
               nreq++;
               cd = LAT + 1;
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = int'(bus_rdata);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig_req = 1'b1;
      @(negedge clk); trig_req = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      int n;
      n = 0;
      while (!irq && n < 500) begin
         @(negedge clk);
         n++;
      end
      check(req, int'(irq), 1);
   endtask

   function automatic int seq_len(input int code);
      if (code >= 8 || code == 0) return 8;
      return code;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int v, base, len, mask;
      trig_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(4'd1, v); check("R1 reset length code", v, 16'h0004);
      rd(4'd3, v); check("R4 reset status", v, 0);
      rd(4'd4, v); check("R5 reset flags", v, 0);
      check("R10 reset irq", int'(irq), 0);

      // sweep: every length code, both channel modes, every first channel
      wr(4'd0, 16'h0001);
      for (int code = 0; code < 16; code++) begin
         for (int m = 0; m < 2; m++) begin
            for (int c0 = 0; c0 < 8; c0++) begin
               len = seq_len(code);
               mask = (1 << len) - 1;
               wr(4'd1, 16'(code));
               base = nconv;
               wr(4'd2, 16'((m << 8) | c0));
               wait_irq("R3 single sequence done");
               repeat (4) @(negedge clk);
               check("R1 conversions per sequence", nconv - base, len);
               for (int i = 0; i < len; i++)
                  check("R2 channel order", log_chan[base + i], m ? (c0 + i) % 8 : c0);
               rd(4'd3, v); check("R4 pointer back at slot 0", v & 16'h0007, 0);
               rd(4'd4, v); check("R5 slot flags set", v, mask);
               for (int i = 0; i < len; i++) begin
                  rd(4'(8 + i), v);
                  check("R5 result stored", v, log_data[base + i]);
               end
               rd(4'd4, v); check("R6 only armed slot cleared", v, mask & ~1);
            end
         end
      end

      // R6 normal clear needs a preceding flag read
      wr(4'd1, 16'h0003);
      wr(4'd2, 16'h0001);
      wait_irq("R3 done before clear test");
      rd(4'd9, v);
      rd(4'd4, v); check("R6 unarmed read keeps flag", v, 8'h07);
      rd(4'd9, v);
      rd(4'd4, v); check("R6 armed read clears slot 1", v, 8'h05);

      // R7 fast clear
      wr(4'd0, 16'h0003);
      wr(4'd2, 16'h0001);
      wait_irq("R3 done before fast clear");
      rd(4'd10, v);
      rd(4'd4, v); check("R7 fast clear slot 2", v, 8'h03);
      rd(4'd3, v); check("R7 fast clear done flag", (v >> 15) & 1, 0);
      check("R10 irq drops with done flag", int'(irq), 0);

      // R8 and R10
      wr(4'd0, 16'h0000);
      wr(4'd2, 16'h0002);
      repeat (40) @(negedge clk);
      rd(4'd3, v);
      check("R10 done flag set", (v >> 15) & 1, 1);
      check("R10 gated status bit", (v >> 13) & 1, 0);
      check("R10 gated irq", int'(irq), 0);
      wr(4'd0, 16'h0001);
      check("R10 irq follows enable", int'(irq), 1);
      wr(4'd3, 16'h8000);
      rd(4'd3, v); check("R8 write one clears done", (v >> 15) & 1, 0);

      // R4 FIFO ring, R9 overrun, R12, R13 trigger
      wr(4'd1, 16'h0013);
      base = nconv;
      wr(4'd2, 16'h0100);
      wait_irq("R3 fifo first sequence");
      rd(4'd3, v); check("R4 fifo pointer after one", v & 7, 3);
      wr(4'd3, 16'h8000);
      pulse_trig();
      wait_irq("R13 trigger starts sequence");
      rd(4'd3, v); check("R4 fifo pointer after two", v & 7, 6);
      rd(4'd4, v); check("R13 flags kept", v, 8'h3F);
      check("R13 channel restarts at base", log_chan[base + 3], 0);
      rd(4'd12, v); check("R4 fifo slot 4 result", v, log_data[base + 4]);
      wr(4'd3, 16'h0007);
      rd(4'd3, v); check("R12 status write keeps pointer", v & 7, 6);
      rd(4'd4, v); check("R12 status write keeps flags", v, 8'h2F);
      wr(4'd3, 16'h8000);
      pulse_trig();
      wait_irq("R13 second trigger");
      rd(4'd3, v);
      check("R4 fifo pointer wraps", v & 7, 1);
      check("R9 overrun set", (v >> 14) & 1, 1);
      rd(4'd8, v); check("R4 wrapped write to slot 0", v, log_data[base + 8]);
      wr(4'd3, 16'h4000);
      rd(4'd3, v); check("R9 write one clears overrun", (v >> 14) & 1, 0);
      wr(4'd0, 16'h0001);
      rd(4'd3, v); check("R4 control write clears pointer", v & 7, 0);

      // R3 repeat mode with channel wrap, R11 abort
      wr(4'd1, 16'h0002);
      base = nconv;
      wr(4'd2, 16'h0307);
      wait_irq("R3 repeat first");
      wr(4'd3, 16'h8000);
      wait_irq("R3 repeat second");
      check("R3 repeat chan a", log_chan[base + 2], 7);
      check("R2 walking wrap", log_chan[base + 3], 0);
      base = nconv;
      wr(4'd2, 16'h0002);
      rd(4'd4, v); check("R5 start clears flags", v, 0);
      wait_irq("R11 restart completes");
      repeat (20) @(negedge clk);
      check("R11 new sequence single", nconv - base, 2);
      check("R11 new channel", log_chan[base], 2);
      wr(4'd2, 16'h0201);
      repeat (6) @(negedge clk);
      wr(4'd1, 16'h0002);
      base = nconv;
      repeat (30) @(negedge clk);
      check("R11 abort stops requests", nconv - base, 0);
      rd(4'd3, v); check("R11 abort pointer", v & 7, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule